// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port and an asynchronous static RAM of 128K words by 16 bits with two byte lanes. Each accepted request is either one word write or one word read. The block turns it into a timed sequence on the memory's active-low chip enable, write enable, output enable and per-lane byte enables. It drives a split data bus made of an output value, a bus output enable and an input value, so a pad ring or a board-level tristate buffer can be placed at the chip edge.

The length of every phase is derived at elaboration time from the memory's AC limits in nanoseconds and from the clock period. Each limit is rounded up to whole cycles, with a floor of one cycle. Writes are controlled by write enable: output enable stays high, chip enable and write enable fall and rise together, and the data bus is released on the rising edge. Reads hold chip enable and output enable low and capture the data on the edge that ends the access. After a read, a recovery gap lets the memory's outputs go to high impedance before anything else can be driven.

A request whose two byte enables are both clear finishes at once, without a memory cycle. Byte lanes that a read did not enable return zero.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, mem_ce_n, mem_we_n, mem_oe_n and both mem_be_n bits are 1, mem_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. After a request that has at least one byte enable set, req_ready is 0 until the memory cycle and its recovery phase are complete.
- R3: A write holds mem_ce_n and mem_we_n low together for the write-low count of cycles, while mem_oe_n stays high. With a 5 ns clock this count is 10 cycles: the largest of the rounded-up 40 ns pulse, 45 ns address and chip-enable setup, 50 ns byte-enable setup and 25 ns data setup. mem_dq_oe is 1 for that whole window. mem_we_n, mem_ce_n and mem_dq_oe all change on the same edge that ends the write.
- R4: After a write ends, req_ready stays 0 so that the accepted write occupies at least ceil(55 ns / period) cycles, with at least one recovery cycle (11 cycles in total at 5 ns).
- R5: req_be bit 0 selects data bits 7:0 and drives mem_be_n[0] low. req_be bit 1 selects bits 15:8 and drives mem_be_n[1] low. A partial write leaves the bytes that were not enabled unchanged. Both mem_be_n bits are high whenever mem_ce_n is high.
- R6: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for ceil(max(55 ns, 55 ns, 25 ns) / period) cycles (11 at 5 ns). The data is captured on the edge that ends this phase, and rsp_valid is 1 for the single cycle that follows that edge, 11 edges after the accepting edge.
- R7: In rsp_rdata, a byte lane that the read did not enable is zero.
- R8: After a read, req_ready stays 0 for ceil(25 ns / period) cycles after mem_oe_n rises. mem_dq_oe is never 1 while mem_oe_n is 0.
- R9: A request with req_be = 0 starts no memory cycle and leaves req_ready at 1. For a read, rsp_valid is 1 with rsp_rdata = 0 in the cycle after the accepting edge.
- R10: mem_addr does not change while mem_ce_n is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request is taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high byte enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 = low lane |
| mem_dq_o | output | 16 | Data bus value driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus value from memory |

## Verification
On every cycle, the assertions check the following:
- the relationships between the control strobes (write enable only inside chip enable with output enable high, output enable only with write enable high);
- the exact width of the write-enable pulse, and that the data bus is released on its rising edge;
- that the data bus is never driven while output enable is low;
- that the address stays stable while the chip is selected;
- how the handshake responds to zero and non-zero byte enables.

Only the bench scenarios can show the following:
- the nanosecond margins seen by the memory (setup to the end of the write, access time before capture, the release gap before the bus is driven again, the write cycle time);
- the data that a partial write leaves behind;
- the zeroing of disabled read lanes.

The bench shows these through a timed behavioural memory model and a scoreboard of expected read data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WREC,
    ST_RD,
    ST_RREC
  } ctl_state_e;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_wr,
  input  logic [7:0] wr_byte,
  input  logic       cap,
  input  logic       clr,
  input  logic       lane_on,
  input  logic [7:0] rd_byte,
  output logic [7:0] wr_q,
  output logic [7:0] rd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (load_wr) wr_q <= wr_byte;
      if (clr) begin
        rd_q <= '0;
      end else if (cap) begin
        rd_q <= lane_on ? rd_byte : 8'h00;
      end
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_WPULSE_NS   = 40,
  parameter int unsigned T_ADDR_WE_NS  = 45,
  parameter int unsigned T_BYTE_WE_NS  = 50,
  parameter int unsigned T_DSETUP_NS   = 25,
  parameter int unsigned T_WCYCLE_NS   = 55,
  parameter int unsigned T_RCYCLE_NS   = 55,
  parameter int unsigned T_ACCESS_NS   = 55,
  parameter int unsigned T_OE_DATA_NS  = 25,
  parameter int unsigned T_OE_HIZ_NS   = 25
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_ce_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [DATA_W/8-1:0]    mem_be_n,
  output logic [DATA_W-1:0]      mem_dq_o,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_i
);

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned N_WLOW  = umax(umax(ns2cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                              ns2cyc(T_ADDR_WE_NS, CLK_PERIOD_NS)),
                                         umax(ns2cyc(T_BYTE_WE_NS, CLK_PERIOD_NS),
                                              ns2cyc(T_DSETUP_NS, CLK_PERIOD_NS)));
  localparam int unsigned N_WC    = ns2cyc(T_WCYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned N_WREC  = (N_WC > N_WLOW) ? (N_WC - N_WLOW) : 1;
  localparam int unsigned N_RD    = umax(umax(ns2cyc(T_RCYCLE_NS, CLK_PERIOD_NS),
                                              ns2cyc(T_ACCESS_NS, CLK_PERIOD_NS)),
                                         ns2cyc(T_OE_DATA_NS, CLK_PERIOD_NS));
  localparam int unsigned N_RREC  = ns2cyc(T_OE_HIZ_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX = umax(umax(N_WLOW, N_WREC), umax(N_RD, N_RREC));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  ctl_state_e       state_q, state_d;
  logic             tmr_ld, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, any_be, start_wr, start_rd, zero_rd, wr_end, rd_end;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign any_be    = |req_be;
  assign start_wr  = accept && any_be && req_write;
  assign start_rd  = accept && any_be && !req_write;
  assign zero_rd   = accept && !any_be && !req_write;
  assign wr_end    = (state_q == ST_WR) && tmr_done;
  assign rd_end    = (state_q == ST_RD) && tmr_done;

  // phase sequencing
  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_wr) begin
          state_d = ST_WR;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(N_WLOW - 1);
        end else if (start_rd) begin
          state_d = ST_RD;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(N_RD - 1);
        end
      end
      ST_WR: begin
        if (tmr_done) begin
          state_d = ST_WREC;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(N_WREC - 1);
        end
      end
      ST_RD: begin
        if (tmr_done) begin
          state_d = ST_RREC;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(N_RREC - 1);
        end
      end
      ST_WREC, ST_RREC: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // registered memory-side strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rd_end || zero_rd;
      if (start_wr || start_rd) begin
        mem_addr <= req_addr;
        mem_ce_n <= 1'b0;
        mem_be_n <= ~req_be;
      end
      if (start_wr) begin
        mem_we_n  <= 1'b0;
        mem_dq_oe <= 1'b1;
      end
      if (start_rd) mem_oe_n <= 1'b0;
      if (wr_end) begin
        mem_ce_n  <= 1'b1;
        mem_we_n  <= 1'b1;
        mem_be_n  <= '1;
        mem_dq_oe <= 1'b0;
      end
      if (rd_end) begin
        mem_ce_n <= 1'b1;
        mem_oe_n <= 1'b1;
        mem_be_n <= '1;
      end
    end
  end

  // byte lanes: write data hold and masked read capture
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_ctl_lane u_lane (
      .clk     (clk),
      .rst     (rst),
      .load_wr (start_wr),
      .wr_byte (req_wdata[i*8 +: 8]),
      .cap     (rd_end),
      .clr     (zero_rd),
      .lane_on (!mem_be_n[i]),
      .rd_byte (mem_dq_i[i*8 +: 8]),
      .wr_q    (mem_dq_o[i*8 +: 8]),
      .rd_q    (rsp_rdata[i*8 +: 8])
    );
  end

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned LANES  = 2,
  parameter int unsigned WE_CYC = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_be,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_run;

  always_ff @(posedge clk) begin
    if (rst) we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 16'd1;
    else we_run <= '0;
  end

  // R3
  we_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run == 16'(WE_CYC)));

  // R3
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_dq_oe && mem_ce_n));

  // R6
  oe_we_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R2
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (|req_be)) |=> !req_ready);

  // R9
  zero_be_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !(|req_be)) |=> (req_ready && mem_ce_n));

  // R5
  be_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (&mem_be_n));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .WE_CYC (N_WLOW)
) chk_i (.*);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  localparam int P      = 5;
  localparam int W_LOW  = (50 + P - 1) / P;
  localparam int W_CYC  = (55 + P - 1) / P;
  localparam int R_ACC  = (55 + P - 1) / P;
  localparam int R_GAP  = (25 + P - 1) / P;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hC3C3;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- timed memory model ----------------
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  int   t_now = 0;
  int   t_addr = -1000, t_we_fall = -1000, t_ce_fall = -1000, t_data = -1000;
  int   t_oe_fall = -1000, t_oe_rise = -1000, t_wstart = -1000;
  int   t_be_low [2] = '{-1000, -1000};
  logic p_ce, p_we, p_oe, p_dqoe;
  logic [1:0]  p_be;
  logic [16:0] p_addr;
  logic [15:0] p_dqo;

  function automatic logic [15:0] mrd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      t_now += P;
      if (mem_addr != p_addr) begin
        t_addr = t_now;
        chk(!(!mem_ce_n && !p_ce), "R10", mem_addr, p_addr);
      end
      if (p_ce && !mem_ce_n) t_ce_fall = t_now;
      if (p_oe && !mem_oe_n) t_oe_fall = t_now;
      if (!p_oe && mem_oe_n) t_oe_rise = t_now;
      for (int i = 0; i < 2; i++) if (p_be[i] && !mem_be_n[i]) t_be_low[i] = t_now;
      if (p_we && !mem_we_n) begin
        chk(t_now - t_wstart >= 55, "R4", t_now - t_wstart, 55);
        t_wstart = t_now;
      end
      if (mem_dq_oe && (!p_dqoe || mem_dq_o != p_dqo)) t_data = t_now;
      if (mem_dq_oe && !p_dqoe) begin
        chk(t_now - t_oe_rise >= 25, "R8", t_now - t_oe_rise, 25);
      end
      if (!mem_we_n && !mem_oe_n) chk(0, "R3", mem_oe_n, 1);
      // write end: chip enable and write enable no longer both low
      if (!p_ce && !p_we && !(!mem_ce_n && !mem_we_n)) begin
        logic [15:0] w;
        chk(t_now - t_we_fall >= 40, "R3", t_now - t_we_fall, 40);
        chk(t_now - t_ce_fall >= 45 && t_now - t_addr >= 45, "R3", t_now - t_addr, 45);
        chk(t_now - t_data >= 25 && p_dqoe, "R3", t_now - t_data, 25);
        w = mrd(int'(p_addr));
        for (int i = 0; i < 2; i++) if (!p_be[i]) begin
          chk(t_now - t_be_low[i] >= 50, "R5", t_now - t_be_low[i], 50);
          w[i*8 +: 8] = p_dqo[i*8 +: 8];
        end
        mem[int'(p_addr)] = w;
      end
      if (p_we && !mem_we_n) t_we_fall = t_now;
      // read data presented for the next rising edge
      begin
        logic [15:0] r;
        r = 16'hC3C3;
        if (!mem_ce_n && !mem_oe_n && mem_we_n &&
            (t_now + P - t_addr >= 55) && (t_now + P - t_oe_fall >= 25) &&
            (t_now + P - t_ce_fall >= 55)) begin
          for (int i = 0; i < 2; i++) if (!mem_be_n[i]) r[i*8 +: 8] = mrd(int'(mem_addr))[i*8 +: 8];
        end
        mem_dq_i = r;
      end
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_be = mem_be_n;
    p_addr = mem_addr; p_dqo = mem_dq_o; p_dqoe = mem_dq_oe;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [15:0] data; string tag; } exp_t;
  exp_t exp_q [$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R6", rsp_rdata, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e.data, e.tag, rsp_rdata, e.data);
      end
    end
  end

  function automatic logic [15:0] srd(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  // driver: returns at the falling edge after the accepting edge
  task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    if (wr) begin
      logic [15:0] s;
      s = srd(int'(a));
      for (int i = 0; i < 2; i++) if (be[i]) s[i*8 +: 8] = d[i*8 +: 8];
      shadow[int'(a)] = s;
    end else begin
      exp_t e;
      e.data = srd(int'(a)) & {{8{be[1]}}, {8{be[0]}}};
      e.tag  = (be == 2'b00) ? "R9" : ((be == 2'b11) ? "R6" : "R7");
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * P);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    // R1 reset values while held in reset
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(mem_be_n == 2'b11 && !mem_dq_oe, "R1", {mem_be_n, mem_dq_oe}, 3'b110);
    chk(!rsp_valid && req_ready, "R1", {rsp_valid, req_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && req_ready && !mem_dq_oe, "R1", {mem_ce_n, req_ready, mem_dq_oe}, 3'b110);

    // full write, timed: R2 R3 R4 R5
    issue(1, 17'h00010, 16'hABCD, 2'b11);
    chk(!req_ready, "R2", req_ready, 0);
    chk(mem_be_n == 2'b00 && mem_oe_n, "R5", {mem_be_n, mem_oe_n}, 3'b001);
    n = 0;
    while (!mem_we_n) begin n++; @(negedge clk); end
    chk(n == W_LOW, "R3", n, W_LOW);
    chk(!mem_dq_oe && mem_ce_n, "R3", {mem_dq_oe, mem_ce_n}, 2'b01);
    while (!req_ready) begin n++; @(negedge clk); end
    chk(n == W_CYC, "R4", n, W_CYC);

    // full read, timed: R6 R8
    issue(0, 17'h00010, 16'h0, 2'b11);
    n = 0;
    while (!rsp_valid) begin n++; @(negedge clk); end
    chk(n == R_ACC, "R6", n, R_ACC);
    chk(mem_ce_n && mem_oe_n, "R6", {mem_ce_n, mem_oe_n}, 2'b11);
    while (!req_ready) begin n++; @(negedge clk); end
    chk(n == R_ACC + R_GAP, "R8", n, R_ACC + R_GAP);

    // lane masking and partial writes: R5 R7
    issue(0, 17'h00010, 16'h0, 2'b01);
    issue(0, 17'h00010, 16'h0, 2'b10);
    issue(1, 17'h00010, 16'h1234, 2'b10);
    issue(0, 17'h00010, 16'h0, 2'b11);
    issue(1, 17'h1FFFF, 16'h5A5A, 2'b01);
    issue(0, 17'h1FFFF, 16'h0, 2'b11);

    // zero byte enables: R9
    issue(1, 17'h00010, 16'hFFFF, 2'b00);
    chk(req_ready && mem_ce_n, "R9", {req_ready, mem_ce_n}, 2'b11);
    issue(0, 17'h00010, 16'h0, 2'b00);
    chk(rsp_valid && rsp_rdata == 16'h0 && mem_ce_n, "R9", rsp_rdata, 0);
    issue(0, 17'h00010, 16'h0, 2'b11);

    // random traffic over a small address pool, including both ends
    for (int k = 0; k < 300; k++) begin
      logic [16:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel == 0) ? 17'h1FFFF : ((sel == 1) ? 17'h00000 : 17'($urandom_range(0, 5)));
      issue($urandom_range(0, 1), a, 16'($urandom), 2'($urandom_range(0, 3)));
    end

    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule